// File: doc/BRIEF.md
# Dual-Port Host Byte FIFO with Command Steering

This block is the host-facing data staging store of a SCSI controller. A host reaches it through two paths. The register path moves one byte per access. The pseudo-DMA path moves one byte (narrow access) or two bytes (wide access) per access. A 16-byte data FIFO holds the payload. A 32-byte command buffer collects command bytes while the controller is in command phase.

The transfer counter and the phase sequencing live outside the block. The block takes a flag that says the counter is zero, and a command-phase flag. It returns a one-cycle completion pulse that tells the surrounding controller when a pseudo-DMA burst has finished. A pseudo-DMA burst finishes when a write exhausts the count or fills the FIFO, or when a read empties the FIFO. The block also returns one-cycle overrun pulses for the register path and for the command buffer.

At most one access is served per clock. Every output is registered and reflects the access of the previous clock edge.

Top module: `pdma_byte_fifo`

## Requirements
- R1: After synchronous reset the following outputs read 0: `wr_ptr`, `rd_ptr`, `cmd_len`, `reg_rdata`, `pd_rdata`, `pd_done`, `reg_overrun` and `cmd_overrun`.
- R2: A register-path write with `cmd_phase` low behaves as follows.
  - It stores `reg_wdata` at `wr_ptr` and increments `wr_ptr`.
  - If `wr_ptr` is 15 or more (buffer size minus one, or higher), the byte is dropped, the pointer is unchanged, and `reg_overrun` pulses for one cycle.
- R3: A register-path read behaves as follows.
  - If `rd_ptr < wr_ptr`, it loads the byte at `rd_ptr` into `reg_rdata` and increments `rd_ptr`. Otherwise `reg_rdata` keeps its old value.
  - If the two pointers are equal after the read, both become 0.
- R4: A pseudo-DMA write with `cmd_phase` low stores bytes into the data FIFO.
  - A narrow write stores `pd_wdata[7:0]`.
  - A wide write stores `pd_wdata[15:8]` first and then `pd_wdata[7:0]`.
  - Any byte that would land at position 16 or beyond is dropped silently.
- R5: `pd_done` pulses one cycle after a pseudo-DMA write if either `tc_zero` was high or `wr_ptr` equals 16 after the write.
- R6: A pseudo-DMA read returns its bytes in `pd_rdata`.
  - A narrow read returns `{8'h00, byte}`.
  - A wide read places the first byte in bits 15:8 and the second byte in bits 7:0.
  - A byte position for which the FIFO holds no data returns 0, and `rd_ptr` does not advance past `wr_ptr`.
- R7: After a pseudo-DMA read, if `rd_ptr` equals `wr_ptr`, both pointers become 0 and `pd_done` pulses.
- R8: While `cmd_phase` is high, writes from either path go to the command buffer and leave the data FIFO unchanged.
  - Each byte is stored at `cmd_len`, and `cmd_len` increments by one per byte. A wide write stores the high byte first.
  - `cmd_rdata` shows the command byte at `cmd_raddr` one cycle later. If that byte is written in the same cycle, `cmd_rdata` shows the old value.
- R9: A command byte that arrives when `cmd_len` is 32 is dropped, and `cmd_overrun` pulses for one cycle.
- R10: `flush` sets both FIFO pointers to 0. `cmd_clr` sets `cmd_len` to 0, and a command write in the same cycle is ignored.
- R11: When several accesses are requested in one cycle, only the highest-priority one is served. The priority order is `flush`, pseudo-DMA write, pseudo-DMA read, register write, register read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_phase | input | 1 | Steer writes into the command buffer |
| tc_zero | input | 1 | External transfer count is zero |
| flush | input | 1 | Clear FIFO pointers |
| reg_wr | input | 1 | Register-path write strobe |
| reg_rd | input | 1 | Register-path read strobe |
| reg_wdata | input | 8 | Register-path write byte |
| reg_rdata | output | 8 | Register-path read byte |
| reg_overrun | output | 1 | Register write dropped (pulse) |
| pd_wr | input | 1 | Pseudo-DMA write strobe |
| pd_rd | input | 1 | Pseudo-DMA read strobe |
| pd_wide | input | 1 | Pseudo-DMA access is two bytes |
| pd_wdata | input | 16 | Pseudo-DMA write data |
| pd_rdata | output | 16 | Pseudo-DMA read data |
| pd_done | output | 1 | Pseudo-DMA burst completion (pulse) |
| cmd_clr | input | 1 | Clear command length |
| cmd_raddr | input | 5 | Command buffer read address |
| cmd_rdata | output | 8 | Command buffer read byte |
| cmd_len | output | 6 | Command bytes stored |
| cmd_overrun | output | 1 | Command byte dropped (pulse) |
| wr_ptr | output | 5 | Data FIFO write position |
| rd_ptr | output | 5 | Data FIFO read position |

## Verification
Most internal faults in this block show up at the ports within one clock, because the pointers and the command length are brought out directly.

A wrong pointer update also shows up later. It corrupts the bytes that the next reads return, or it moves the point at which `pd_done` or an overrun pulse appears.

A byte-order fault in the wide path appears in `pd_rdata`, or in the command buffer contents, on the very next read of those bytes. The bench therefore compares every output against a behavioural model on every cycle, so a divergence is reported in the cycle in which it first becomes visible.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_FLUSH  = 3'd1,
    OP_PD_WR  = 3'd2,
    OP_PD_RD  = 3'd3,
    OP_REG_WR = 3'd4,
    OP_REG_RD = 3'd5
  } op_e;

  // One served access per clock, bytes already placed in transfer order.
  typedef struct packed {
    op_e        kind;
    logic       two;     // two bytes in this access
    logic       to_cmd;  // command phase active
    logic [7:0] b0;      // first byte in transfer order
    logic [7:0] b1;      // second byte in transfer order
  } req_t;

endpackage

// File: rtl/pdf_req_decode.sv
module pdf_req_decode
  import pdf_pkg::*;
(
  input  logic        flush,
  input  logic        pd_wr,
  input  logic        pd_rd,
  input  logic        pd_wide,
  input  logic [15:0] pd_wdata,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_wdata,
  input  logic        cmd_phase,
  output req_t        req
);

  // Fixed priority: flush, pd write, pd read, reg write, reg read (R11).
  always_comb begin
    req        = '0;
    req.kind   = OP_IDLE;
    req.to_cmd = cmd_phase;
    if (flush) begin
      req.kind = OP_FLUSH;
    end else if (pd_wr) begin
      req.kind = OP_PD_WR;
      req.two  = pd_wide;
      req.b0   = pd_wide ? pd_wdata[15:8] : pd_wdata[7:0];
      req.b1   = pd_wdata[7:0];
    end else if (pd_rd) begin
      req.kind = OP_PD_RD;
      req.two  = pd_wide;
    end else if (reg_wr) begin
      req.kind = OP_REG_WR;
      req.b0   = reg_wdata;
    end else if (reg_rd) begin
      req.kind = OP_REG_RD;
    end
  end

endmodule

// File: rtl/pdf_data_fifo.sv
module pdf_data_fifo
  import pdf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  req_t                       req,
  input  logic                       tc_zero,
  output logic [$clog2(DEPTH):0]     wr_ptr,
  output logic [$clog2(DEPTH):0]     rd_ptr,
  output logic [7:0]                 reg_rdata,
  output logic [15:0]                pd_rdata,
  output logic                       done,
  output logic                       reg_ovr
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL = PW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [7:0] mem [DEPTH];

  logic          dw_reg, dw_pd, pd_wr_any, rd_pd, rd_reg;
  logic          we0, we1, re0, re1, drain;
  logic [PW-1:0] p1, wn, q1, qn;
  logic [7:0]    rbyte0, rbyte1, g0, g1;
  logic          done_n, ovr_n;

  always_comb begin
    pd_wr_any = (req.kind == OP_PD_WR);
    dw_pd     = pd_wr_any && !req.to_cmd;
    dw_reg    = (req.kind == OP_REG_WR) && !req.to_cmd;
    rd_pd     = (req.kind == OP_PD_RD);
    rd_reg    = (req.kind == OP_REG_RD);

    // write side: register path stops one entry short, pd path at the end
    we0   = dw_pd ? (wr_ptr < FULL) : (dw_reg && (wr_ptr < LAST));
    p1    = wr_ptr + PW'(we0);
    we1   = dw_pd && req.two && (p1 < FULL);
    wn    = p1 + PW'(we1);
    ovr_n = dw_reg && !(wr_ptr < LAST);

    // read side
    re0    = (rd_pd || rd_reg) && (rd_ptr < wr_ptr);
    q1     = rd_ptr + PW'(re0);
    re1    = rd_pd && req.two && (q1 < wr_ptr);
    qn     = q1 + PW'(re1);
    drain  = (rd_pd || rd_reg) && (qn == wr_ptr);
    rbyte0 = mem[rd_ptr[AW-1:0]];
    rbyte1 = mem[q1[AW-1:0]];
    g0     = re0 ? rbyte0 : 8'h00;
    g1     = re1 ? rbyte1 : 8'h00;

    done_n = (pd_wr_any && (tc_zero || (wn == FULL))) || (rd_pd && drain);
  end

  // storage without reset so it maps onto plain RAM cells
  always_ff @(posedge clk) begin
    if (we0) mem[wr_ptr[AW-1:0]] <= req.b0;
    if (we1) mem[p1[AW-1:0]]     <= req.b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      reg_rdata <= '0;
      pd_rdata  <= '0;
      done      <= 1'b0;
      reg_ovr   <= 1'b0;
    end else begin
      done    <= done_n;
      reg_ovr <= ovr_n;
      if (req.kind == OP_FLUSH) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else if (dw_pd || dw_reg) begin
        wr_ptr <= wn;
      end else if (rd_pd || rd_reg) begin
        if (drain) begin
          wr_ptr <= '0;
          rd_ptr <= '0;
        end else begin
          rd_ptr <= qn;
        end
      end
      if (rd_pd) pd_rdata <= req.two ? {g0, g1} : {8'h00, g0};
      if (rd_reg && re0) reg_rdata <= rbyte0;
    end
  end

  // pointer ordering is an invariant of every operation
  p_ptr_order_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_ptr <= wr_ptr) && (wr_ptr <= FULL));

  p_reg_overrun_r2: assert property (@(posedge clk) disable iff (rst)
    (req.kind == OP_REG_WR && !req.to_cmd && wr_ptr >= LAST)
      |=> (reg_ovr && $stable(wr_ptr)));

  p_wide_write_r4: assert property (@(posedge clk) disable iff (rst)
    (req.kind == OP_PD_WR && !req.to_cmd && req.two && wr_ptr <= FULL - 2)
      |=> (wr_ptr == $past(wr_ptr) + PW'(2)));

  p_pd_drain_r7: assert property (@(posedge clk) disable iff (rst)
    (req.kind == OP_PD_RD) |=> (done == (wr_ptr == '0 && rd_ptr == '0)));

  p_flush_r10: assert property (@(posedge clk) disable iff (rst)
    (req.kind == OP_FLUSH) |=> (wr_ptr == '0 && rd_ptr == '0 && !reg_ovr));

endmodule

// File: rtl/pdf_cmd_buf.sv
module pdf_cmd_buf
  import pdf_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  req_t                   req,
  input  logic                   clr,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [$clog2(DEPTH):0] len,
  output logic [7:0]             rdata,
  output logic                   ovr
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [7:0] mem [DEPTH];

  logic          wr, we0, we1, ovr_n;
  logic [LW-1:0] l1, ln;

  always_comb begin
    wr    = req.to_cmd && !clr &&
            (req.kind == OP_PD_WR || req.kind == OP_REG_WR);
    we0   = wr && (len < FULL);
    l1    = len + LW'(we0);
    we1   = wr && req.two && (l1 < FULL);
    ln    = l1 + LW'(we1);
    ovr_n = wr && (!(len < FULL) || (req.two && !(l1 < FULL)));
  end

  // read-first synchronous port, two write lanes
  always_ff @(posedge clk) begin
    if (we0) mem[len[AW-1:0]] <= req.b0;
    if (we1) mem[l1[AW-1:0]]  <= req.b1;
    rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len <= '0;
      ovr <= 1'b0;
    end else begin
      ovr <= ovr_n;
      if (clr) len <= '0;
      else     len <= ln;
    end
  end

  p_cmd_bound_r9: assert property (@(posedge clk) disable iff (rst)
    len <= FULL);

  p_cmd_overrun_r9: assert property (@(posedge clk) disable iff (rst)
    (wr && len == FULL) |=> (ovr && len == FULL));

  p_cmd_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (len == '0));

endmodule

// File: rtl/pdma_byte_fifo.sv
module pdma_byte_fifo
  import pdf_pkg::*;
#(
  parameter int DATA_DEPTH = 16,
  parameter int CMD_DEPTH  = 32,
  localparam int DAW = $clog2(DATA_DEPTH),
  localparam int CAW = $clog2(CMD_DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_phase,
  input  logic           tc_zero,
  input  logic           flush,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  output logic           reg_overrun,
  input  logic           pd_wr,
  input  logic           pd_rd,
  input  logic           pd_wide,
  input  logic [15:0]    pd_wdata,
  output logic [15:0]    pd_rdata,
  output logic           pd_done,
  input  logic           cmd_clr,
  input  logic [CAW-1:0] cmd_raddr,
  output logic [7:0]     cmd_rdata,
  output logic [CAW:0]   cmd_len,
  output logic           cmd_overrun,
  output logic [DAW:0]   wr_ptr,
  output logic [DAW:0]   rd_ptr
);

  req_t req;

  pdf_req_decode u_dec (
    .flush     (flush),
    .pd_wr     (pd_wr),
    .pd_rd     (pd_rd),
    .pd_wide   (pd_wide),
    .pd_wdata  (pd_wdata),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .cmd_phase (cmd_phase),
    .req       (req)
  );

  pdf_data_fifo #(.DEPTH(DATA_DEPTH)) u_data (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .tc_zero   (tc_zero),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .reg_rdata (reg_rdata),
    .pd_rdata  (pd_rdata),
    .done      (pd_done),
    .reg_ovr   (reg_overrun)
  );

  pdf_cmd_buf #(.DEPTH(CMD_DEPTH)) u_cmd (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .clr   (cmd_clr),
    .raddr (cmd_raddr),
    .len   (cmd_len),
    .rdata (cmd_rdata),
    .ovr   (cmd_overrun)
  );

  // a flush in the same cycle as a write must leave the FIFO empty (R11)
  p_flush_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (flush && (reg_wr || pd_wr)) |=> (wr_ptr == '0 && !reg_overrun));

endmodule

// File: tb/pdma_byte_fifo_test.sv
module pdma_byte_fifo_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_phase = 0, tc_zero = 0, flush = 0;
  logic        reg_wr = 0, reg_rd = 0, pd_wr = 0, pd_rd = 0, pd_wide = 0;
  logic        cmd_clr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [15:0] pd_wdata = 0;
  logic [4:0]  cmd_raddr = 0;
  logic [7:0]  reg_rdata, cmd_rdata;
  logic [15:0] pd_rdata;
  logic        reg_overrun, pd_done, cmd_overrun;
  logic [5:0]  cmd_len;
  logic [4:0]  wr_ptr, rd_ptr;

  always #4 clk = ~clk;

  pdma_byte_fifo uut (
    .clk(clk), .rst(rst), .cmd_phase(cmd_phase), .tc_zero(tc_zero),
    .flush(flush), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_overrun(reg_overrun), .pd_wr(pd_wr),
    .pd_rd(pd_rd), .pd_wide(pd_wide), .pd_wdata(pd_wdata),
    .pd_rdata(pd_rdata), .pd_done(pd_done), .cmd_clr(cmd_clr),
    .cmd_raddr(cmd_raddr), .cmd_rdata(cmd_rdata), .cmd_len(cmd_len),
    .cmd_overrun(cmd_overrun), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
  );

  int total = 0, bad = 0;

  // behavioural reference
  int  wp = 0, rp = 0, clen = 0;
  byte dm [16];
  byte cm [32];
  bit  cv [32];
  int  e_reg = 0, e_pd = 0, e_cmd = 0;
  bit  e_cmd_known = 0, e_done = 0, e_rovr = 0, e_covr = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cmd_put(input byte b);
    if (clen < 32) begin cm[clen] = b; cv[clen] = 1; clen++; end
    else e_covr = 1;
  endtask

  task automatic model();
    byte g0, g1;
    e_done = 0; e_rovr = 0; e_covr = 0;
    e_cmd = int'(cm[cmd_raddr]) & 255; e_cmd_known = cv[cmd_raddr];
    if (cmd_clr) clen = 0;
    if (flush) begin
      wp = 0; rp = 0;
    end else if (pd_wr) begin
      if (cmd_phase) begin
        if (!cmd_clr) begin
          if (pd_wide) begin cmd_put(pd_wdata[15:8]); cmd_put(pd_wdata[7:0]); end
          else cmd_put(pd_wdata[7:0]);
        end
      end else begin
        if (pd_wide) begin
          if (wp < 16) begin dm[wp] = pd_wdata[15:8]; wp++; end
          if (wp < 16) begin dm[wp] = pd_wdata[7:0]; wp++; end
        end else if (wp < 16) begin dm[wp] = pd_wdata[7:0]; wp++; end
      end
      e_done = tc_zero || (wp == 16);
    end else if (pd_rd) begin
      g0 = 0; g1 = 0;
      if (rp < wp) begin g0 = dm[rp]; rp++; end
      if (pd_wide && rp < wp) begin g1 = dm[rp]; rp++; end
      e_pd = pd_wide ? ((int'(g0) & 255) << 8) | (int'(g1) & 255) : (int'(g0) & 255);
      if (rp == wp) begin rp = 0; wp = 0; e_done = 1; end
    end else if (reg_wr) begin
      if (cmd_phase) begin
        if (!cmd_clr) cmd_put(reg_wdata);
      end else if (wp >= 15) e_rovr = 1;
      else begin dm[wp] = reg_wdata; wp++; end
    end else if (reg_rd) begin
      if (rp < wp) begin e_reg = int'(dm[rp]) & 255; rp++; end
      if (rp == wp) begin rp = 0; wp = 0; end
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "wr_ptr", int'(wr_ptr), wp);
    chk(tag, "rd_ptr", int'(rd_ptr), rp);
    chk(tag, "cmd_len", int'(cmd_len), clen);
    chk(tag, "reg_rdata", int'(reg_rdata), e_reg);
    chk(tag, "pd_rdata", int'(pd_rdata), e_pd);
    chk(tag, "pd_done", int'(pd_done), int'(e_done));
    chk(tag, "reg_overrun", int'(reg_overrun), int'(e_rovr));
    chk(tag, "cmd_overrun", int'(cmd_overrun), int'(e_covr));
    if (e_cmd_known) chk(tag, "cmd_rdata", int'(cmd_rdata), e_cmd);
  endtask

  // inputs are set at a falling edge, served at the rising edge,
  // and results compared at the following falling edge
  task automatic cyc(input string tag);
    @(posedge clk);
    @(negedge clk);
    model();
    compare(tag);
    flush = 0; reg_wr = 0; reg_rd = 0; pd_wr = 0; pd_rd = 0; pd_wide = 0;
    cmd_clr = 0;
  endtask

  task automatic rwr(input byte b, input string tag);
    reg_wr = 1; reg_wdata = b; cyc(tag);
  endtask
  task automatic rrd(input string tag);
    reg_rd = 1; cyc(tag);
  endtask
  task automatic pwr(input bit wide, input logic [15:0] d, input string tag);
    pd_wr = 1; pd_wide = wide; pd_wdata = d; cyc(tag);
  endtask
  task automatic prd(input bit wide, input string tag);
    pd_rd = 1; pd_wide = wide; cyc(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cyc("R1");

    // register path basic flow
    rwr(8'h11, "R2"); rwr(8'h22, "R2"); rwr(8'h33, "R2");
    rrd("R3"); rrd("R3"); rrd("R3");
    rrd("R3");                                  // empty: value holds
    chk("R3", "hold", int'(reg_rdata), 8'h33);

    // pseudo-DMA byte order
    pwr(0, 16'hEE44, "R4"); pwr(1, 16'hA1B2, "R4");
    prd(1, "R6");
    chk("R6", "wide order", int'(pd_rdata), 16'h44A1);
    prd(1, "R7");                               // one byte left, drains
    chk("R7", "partial wide", int'(pd_rdata), 16'hB200);
    chk("R7", "drain done", int'(pd_done), 1);
    prd(0, "R7");                               // empty read

    // completion on count exhaustion
    tc_zero = 1; pwr(0, 16'h0055, "R5");
    tc_zero = 0; pwr(0, 16'h0066, "R5");
    chk("R5", "no done", int'(pd_done), 0);
    flush = 1; cyc("R10");

    // register overrun one entry early, then pd fills the last entry
    for (int i = 0; i < 16; i++) rwr(byte'(8'h80 + i), "R2");
    chk("R2", "early overrun", int'(reg_overrun), 1);
    pwr(0, 16'h0077, "R5");
    chk("R5", "full done", int'(pd_done), 1);
    pwr(1, 16'h1234, "R4");                     // dropped silently
    rwr(8'h99, "R2");
    rrd("R3");
    flush = 1; cyc("R10");

    // wide write straddling the end
    for (int i = 0; i < 15; i++) rwr(byte'(i + 1), "R2");
    pwr(1, 16'hC3D4, "R4");
    chk("R4", "straddle wp", int'(wr_ptr), 16);
    for (int i = 0; i < 16; i++) rrd("R3");
    chk("R3", "last byte", int'(reg_rdata), 8'hC3);

    // command phase steering
    cmd_phase = 1;
    rwr(8'h90, "R8"); pwr(1, 16'h9192, "R8");
    cmd_raddr = 5'd1; cyc("R8");
    cyc("R8");
    chk("R8", "cmd byte", int'(cmd_rdata), 8'h91);
    cmd_raddr = 5'd2; cyc("R8");
    for (int i = 0; i < 30; i++) rwr(byte'(8'h40 + i), "R9");
    chk("R9", "cmd overrun", int'(cmd_overrun), 1);
    pwr(1, 16'h5A5A, "R9");
    cmd_clr = 1; reg_wr = 1; reg_wdata = 8'h01; cyc("R10");
    chk("R10", "cmd cleared", int'(cmd_len), 0);
    pwr(0, 16'h00AB, "R8");
    cmd_phase = 0;

    // priority between simultaneous requests
    flush = 1; reg_wr = 1; reg_wdata = 8'h21; cyc("R11");
    pd_wr = 1; pd_wdata = 16'h0031; reg_wr = 1; reg_wdata = 8'h32; cyc("R11");
    pd_rd = 1; reg_rd = 1; cyc("R11");
    chk("R11", "pd first", int'(pd_rdata), 16'h0031);
    reg_wr = 1; reg_wdata = 8'h41; reg_rd = 1; cyc("R11");
    chk("R11", "reg wr wins", int'(wr_ptr), 1);
    rrd("R3");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule